// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block decides where each of the two ALU operands comes from while an instruction sits in the execute stage of a five-stage integer pipeline. It looks at the instruction word held for the consumer, the consumer's source register numbers, and at the two older instructions still in flight. Each older instruction carries a valid bit and a producer class. For each operand it picks one of four values: the register-file read, the ALU result one stage ahead, the ALU result two stages ahead, or the loaded data two stages ahead.

Which field names an older instruction's destination depends on its class. A register-register operation writes the register named by its rd field. An immediate-form ALU operation and a load write the register named by rt. A load's data only exists once the memory stage is done, so a load one stage ahead is never a forwarding source.

The block also contains the operand multiplexers. Both select codes and both chosen operands are registered, so they appear one clock after the latch contents are presented.

Top module: `fwd_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both select outputs become 0 and both operand outputs become 0 after that edge.
- R2: Register fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11. Producer class codes are 0 none (store, branch, other), 1 register-register ALU, 2 ALU-immediate, 3 load. A class-1 producer's destination is its rd field. A class-2 or class-3 producer's destination is its rt field, and its rd field is ignored.
- R3: The upper operand (`sel_a`, `opnd_a`) is matched against the consumer's rs field, and the lower operand (`sel_b`, `opnd_b`) against its rt field, each on its own.
- R4: Select codes are 0 register file, 1 EX/MEM ALU result, 2 MEM/WB ALU result, 3 MEM/WB load data. When a valid class-1 or class-2 EX/MEM producer's destination matches an operand's source, that operand gets code 1 and the EX/MEM ALU result.
- R5: When a valid class-1 or class-2 MEM/WB producer's destination matches and EX/MEM does not, the operand gets code 2 and the MEM/WB ALU result.
- R6: When a valid class-3 MEM/WB producer's rt matches and EX/MEM does not, the operand gets code 3 and the MEM/WB load data.
- R7: A class-3 producer in EX/MEM never causes forwarding. Such an operand falls through to the MEM/WB check or to the register file.
- R8: When both EX/MEM and MEM/WB match the same operand, the EX/MEM result is chosen.
- R9: A producer whose destination is register 0, or whose valid bit is low, never causes forwarding.
- R10: A class-0 producer never causes forwarding, whatever its fields hold.
- R11: When `idex_valid` is low, both operands select the register file (code 0).
- R12: The select codes and operands for the latch contents present at one rising edge appear on the outputs right after that edge, and none of the inputs on the operand paths waits further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idex_instr | input | 32 | Consumer instruction word in the ID/EX latch |
| idex_valid | input | 1 | Consumer is a real instruction, not a bubble |
| rf_a | input | 32 | Register-file value for the rs operand |
| rf_b | input | 32 | Register-file value for the rt operand |
| exmem_instr | input | 32 | Instruction word in the EX/MEM latch |
| exmem_valid | input | 1 | EX/MEM holds a real instruction |
| exmem_class | input | 2 | Producer class of the EX/MEM instruction |
| exmem_alu_result | input | 32 | ALU output held in EX/MEM |
| memwb_instr | input | 32 | Instruction word in the MEM/WB latch |
| memwb_valid | input | 1 | MEM/WB holds a real instruction |
| memwb_class | input | 2 | Producer class of the MEM/WB instruction |
| memwb_alu_result | input | 32 | ALU output held in MEM/WB |
| memwb_load_data | input | 32 | Loaded data held in MEM/WB |
| sel_a | output | 2 | Registered select for the upper ALU operand |
| sel_b | output | 2 | Registered select for the lower ALU operand |
| opnd_a | output | 32 | Registered upper ALU operand |
| opnd_b | output | 32 | Registered lower ALU operand |

## Verification
The block holds no state apart from its output registers. A wrong comparison, a destination taken from the wrong field, or a wrong priority therefore shows up as a wrong select code and a wrong operand on the very next clock edge, and only for the vector that triggers it. The bench sends each of the ten producer and operand match cases, the priority case, and every suppression case, each followed by other vectors. Every result is compared on the cycle after it is presented, so a fault cannot carry over into a later cycle and hide there. Constrained random vectors with a small register range then make matches between the two operands and the two producers occur at the same time.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_RR   = 2'd1,
    CLS_IMM  = 2'd2,
    CLS_LOAD = 2'd3
  } prod_class_e;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EXA = 2'd1,
    SEL_WBA = 2'd2,
    SEL_WBL = 2'd3
  } opnd_sel_e;
endpackage

// File: rtl/fwd_dest_decode.sv
`timescale 1ns/1ps
// Works out which register a producer writes and whether it may forward.
module fwd_dest_decode
  import fwd_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter bit LOAD_OK = 1'b1
) (
  input  logic              valid,
  input  logic [1:0]        cls,
  input  logic [REG_AW-1:0] rt_fld,
  input  logic [REG_AW-1:0] rd_fld,
  output logic [REG_AW-1:0] dest,
  output logic              live,
  output logic              is_load
);
  logic writer;

  always_comb begin
    dest    = (cls == CLS_RR) ? rd_fld : rt_fld;
    is_load = (cls == CLS_LOAD);
    unique case (cls)
      CLS_RR, CLS_IMM: writer = 1'b1;
      CLS_LOAD:        writer = LOAD_OK;
      default:         writer = 1'b0;
    endcase
    live = valid && writer && (dest != '0);
  end
endmodule

// File: rtl/fwd_select.sv
`timescale 1ns/1ps
// Per-operand priority choice: newer producer first, then older, then register file.
module fwd_select
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              use_valid,
  input  logic [REG_AW-1:0] src,
  input  logic              ex_live,
  input  logic [REG_AW-1:0] ex_dest,
  input  logic              wb_live,
  input  logic [REG_AW-1:0] wb_dest,
  input  logic              wb_is_load,
  output logic [1:0]        sel
);
  logic ex_hit, wb_hit;

  always_comb begin
    ex_hit = ex_live && (ex_dest == src);
    wb_hit = wb_live && (wb_dest == src);
    if (!use_valid)  sel = SEL_RF;
    else if (ex_hit) sel = SEL_EXA;
    else if (wb_hit) sel = wb_is_load ? SEL_WBL : SEL_WBA;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/fwd_operand_mux.sv
`timescale 1ns/1ps
// Four-way operand multiplexer driven by a select code.
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] ex_alu,
  input  logic [XLEN-1:0] wb_alu,
  input  logic [XLEN-1:0] wb_ld,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (sel)
      SEL_EXA: y = ex_alu;
      SEL_WBA: y = wb_alu;
      SEL_WBL: y = wb_ld;
      default: y = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5,
  parameter int RS_LSB = 21,
  parameter int RT_LSB = 16,
  parameter int RD_LSB = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] idex_instr,
  input  logic            idex_valid,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] exmem_instr,
  input  logic            exmem_valid,
  input  logic [1:0]      exmem_class,
  input  logic [XLEN-1:0] exmem_alu_result,
  input  logic [XLEN-1:0] memwb_instr,
  input  logic            memwb_valid,
  input  logic [1:0]      memwb_class,
  input  logic [XLEN-1:0] memwb_alu_result,
  input  logic [XLEN-1:0] memwb_load_data,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b
);
  localparam int NOPND = 2;

  logic              unused_bits;
  logic [REG_AW-1:0] ex_dest, wb_dest;
  logic              ex_live, wb_live, wb_is_load, ex_is_load_unused;
  logic [REG_AW-1:0] src    [NOPND];
  logic [XLEN-1:0]   rf_val [NOPND];
  logic [1:0]        sel_n  [NOPND];
  logic [XLEN-1:0]   opnd_n [NOPND];
  logic [1:0]        sel_q  [NOPND];
  logic [XLEN-1:0]   opnd_q [NOPND];

  // Fields outside the register numbers take no part in the decision.
  assign unused_bits = ^{idex_instr, exmem_instr, memwb_instr};

  assign src[0]    = idex_instr[RS_LSB +: REG_AW];
  assign src[1]    = idex_instr[RT_LSB +: REG_AW];
  assign rf_val[0] = rf_a;
  assign rf_val[1] = rf_b;

  // A load one stage ahead has no data yet, so it is not a source.
  fwd_dest_decode #(.REG_AW(REG_AW), .LOAD_OK(1'b0)) u_ex_dec (
    .valid   (exmem_valid),
    .cls     (exmem_class),
    .rt_fld  (exmem_instr[RT_LSB +: REG_AW]),
    .rd_fld  (exmem_instr[RD_LSB +: REG_AW]),
    .dest    (ex_dest),
    .live    (ex_live),
    .is_load (ex_is_load_unused)
  );

  fwd_dest_decode #(.REG_AW(REG_AW), .LOAD_OK(1'b1)) u_wb_dec (
    .valid   (memwb_valid),
    .cls     (memwb_class),
    .rt_fld  (memwb_instr[RT_LSB +: REG_AW]),
    .rd_fld  (memwb_instr[RD_LSB +: REG_AW]),
    .dest    (wb_dest),
    .live    (wb_live),
    .is_load (wb_is_load)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fwd_select #(.REG_AW(REG_AW)) u_sel (
      .use_valid  (idex_valid),
      .src        (src[g]),
      .ex_live    (ex_live),
      .ex_dest    (ex_dest),
      .wb_live    (wb_live),
      .wb_dest    (wb_dest),
      .wb_is_load (wb_is_load),
      .sel        (sel_n[g])
    );

    fwd_operand_mux #(.XLEN(XLEN)) u_mux (
      .sel    (sel_n[g]),
      .rf_val (rf_val[g]),
      .ex_alu (exmem_alu_result),
      .wb_alu (memwb_alu_result),
      .wb_ld  (memwb_load_data),
      .y      (opnd_n[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[g]  <= SEL_RF;
        opnd_q[g] <= '0;
      end else begin
        sel_q[g]  <= sel_n[g];
        opnd_q[g] <= opnd_n[g];
      end
    end
  end

  assign sel_a  = sel_q[0];
  assign sel_b  = sel_q[1];
  assign opnd_a = opnd_q[0];
  assign opnd_b = opnd_q[1];
endmodule

// File: rtl/fwd_unit_chk.sv
`timescale 1ns/1ps
module fwd_unit_chk
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5,
  parameter int RS_LSB = 21,
  parameter int RT_LSB = 16,
  parameter int RD_LSB = 11
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] idex_instr,
  input logic            idex_valid,
  input logic [XLEN-1:0] exmem_instr,
  input logic            exmem_valid,
  input logic [1:0]      exmem_class,
  input logic [XLEN-1:0] exmem_alu_result,
  input logic            memwb_valid,
  input logic [1:0]      memwb_class,
  input logic [XLEN-1:0] memwb_alu_result,
  input logic [XLEN-1:0] memwb_load_data,
  input logic [1:0]      sel_a,
  input logic [1:0]      sel_b,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sel_a == SEL_RF && sel_b == SEL_RF && opnd_a == '0 && opnd_b == '0));

  // R4 and R12: an EX/MEM pick carries last cycle's EX/MEM ALU result
  assert_exa_value_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    (sel_a == SEL_EXA) |-> (opnd_a == $past(exmem_alu_result)));

  // R7: only a valid non-load writer one stage ahead may be picked
  assert_no_early_load_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (sel_b == SEL_EXA) |->
      $past(exmem_valid && (exmem_class == CLS_RR || exmem_class == CLS_IMM)));

  // R6: load-data pick requires a valid load in MEM/WB, and brings its data
  assert_load_src_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (sel_a == SEL_WBL) |->
      ($past(memwb_valid && memwb_class == CLS_LOAD) && opnd_a == $past(memwb_load_data)));

  // R5: MEM/WB ALU pick brings the MEM/WB ALU result
  assert_wba_value_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (sel_b == SEL_WBA) |-> (opnd_b == $past(memwb_alu_result)));

  // R11: a bubble in ID/EX uses the register file for both operands
  assert_bubble_rf_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(!idex_valid) |-> (sel_a == SEL_RF && sel_b == SEL_RF));

  // R8: a live register-register match one stage ahead always wins
  assert_newest_wins_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(idex_valid && exmem_valid && exmem_class == CLS_RR &&
          exmem_instr[RD_LSB +: REG_AW] != '0 &&
          exmem_instr[RD_LSB +: REG_AW] == idex_instr[RS_LSB +: REG_AW])
      |-> (sel_a == SEL_EXA));

  // R9: source register 0 can never be forwarded
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(idex_instr[RT_LSB +: REG_AW] == '0) |-> (sel_b == SEL_RF));
endmodule

bind fwd_unit fwd_unit_chk #(
  .XLEN(XLEN), .REG_AW(REG_AW), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB), .RD_LSB(RD_LSB)
) u_chk (.*);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] idex_instr, exmem_instr, memwb_instr;
  logic        idex_valid, exmem_valid, memwb_valid;
  logic [1:0]  exmem_class, memwb_class;
  logic [31:0] rf_a, rf_b, exmem_alu_result, memwb_alu_result, memwb_load_data;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0]  sa, sb;
    logic [31:0] oa, ob;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  fwd_unit dut (
    .clk(clk), .rst(rst),
    .idex_instr(idex_instr), .idex_valid(idex_valid), .rf_a(rf_a), .rf_b(rf_b),
    .exmem_instr(exmem_instr), .exmem_valid(exmem_valid), .exmem_class(exmem_class),
    .exmem_alu_result(exmem_alu_result),
    .memwb_instr(memwb_instr), .memwb_valid(memwb_valid), .memwb_class(memwb_class),
    .memwb_alu_result(memwb_alu_result), .memwb_load_data(memwb_load_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [31:0] mk(input int rs, input int rt, input int rd);
    mk = {6'h23, rs[4:0], rt[4:0], rd[4:0], 11'h155};
  endfunction

  // Reference choice written from the requirement list.
  function automatic logic [1:0] ref_sel(input logic [4:0] src);
    logic [4:0] ed, wd;
    logic eok, wok;
    ed  = (exmem_class == 2'd1) ? exmem_instr[15:11] : exmem_instr[20:16];
    wd  = (memwb_class == 2'd1) ? memwb_instr[15:11] : memwb_instr[20:16];
    eok = exmem_valid && (exmem_class == 2'd1 || exmem_class == 2'd2) && ed != 5'd0;
    wok = memwb_valid && (memwb_class != 2'd0) && wd != 5'd0;
    if (!idex_valid)             ref_sel = 2'd0;
    else if (eok && ed == src)   ref_sel = 2'd1;
    else if (wok && wd == src)   ref_sel = (memwb_class == 2'd3) ? 2'd3 : 2'd2;
    else                         ref_sel = 2'd0;
  endfunction

  function automatic logic [31:0] ref_val(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'd1:    ref_val = exmem_alu_result;
      2'd2:    ref_val = memwb_alu_result;
      2'd3:    ref_val = memwb_load_data;
      default: ref_val = rf;
    endcase
  endfunction

  task automatic drive(input logic [31:0] ii, input logic iv,
                       input logic ev, input logic [1:0] ec, input logic [31:0] ei,
                       input logic wv, input logic [1:0] wc, input logic [31:0] wi,
                       input string tag);
    exp_t e;
    idex_instr = ii;  idex_valid = iv;
    exmem_valid = ev; exmem_class = ec; exmem_instr = ei;
    memwb_valid = wv; memwb_class = wc; memwb_instr = wi;
    rf_a = $urandom; rf_b = $urandom;
    exmem_alu_result = $urandom; memwb_alu_result = $urandom; memwb_load_data = $urandom;
    e.sa = ref_sel(ii[25:21]);
    e.sb = ref_sel(ii[20:16]);
    e.oa = ref_val(e.sa, rf_a);
    e.ob = ref_val(e.sb, rf_b);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Monitor: items driven before an edge are compared just after it.
  initial begin
    forever begin
      int n;
      @(posedge clk);
      n = q.size();
      #1;
      for (int i = 0; i < n; i++) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " sel_a"},  {30'd0, sel_a}, {30'd0, e.sa});
        chk({e.tag, " sel_b"},  {30'd0, sel_b}, {30'd0, e.sb});
        chk({e.tag, " opnd_a"}, opnd_a, e.oa);
        chk({e.tag, " opnd_b"}, opnd_b, e.ob);
      end
    end
  end

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idex_instr = mk(5, 6, 0); idex_valid = 1'b1;
    exmem_instr = mk(0, 0, 5); exmem_valid = 1'b1; exmem_class = 2'd1;
    memwb_instr = mk(0, 6, 0); memwb_valid = 1'b1; memwb_class = 2'd3;
    rf_a = 32'h1; rf_b = 32'h2;
    exmem_alu_result = 32'hA; memwb_alu_result = 32'hB; memwb_load_data = 32'hC;
    repeat (3) @(negedge clk);
    chk("R1 reset sel_a",  {30'd0, sel_a}, 32'd0);
    chk("R1 reset sel_b",  {30'd0, sel_b}, 32'd0);
    chk("R1 reset opnd_a", opnd_a, 32'd0);
    chk("R1 reset opnd_b", opnd_b, 32'd0);
    rst = 1'b0;

    // The ten producer/operand cases (R3 rs->upper, rt->lower)
    drive(mk(5, 6, 0), 1, 1, 2'd1, mk(0, 0, 5), 0, 2'd0, 0, "R4 R3 EX rr rs");
    drive(mk(5, 6, 0), 1, 1, 2'd1, mk(0, 0, 6), 0, 2'd0, 0, "R4 R3 EX rr rt");
    drive(mk(5, 6, 0), 1, 1, 2'd2, mk(1, 5, 9), 0, 2'd0, 0, "R4 R2 EX imm rs");
    drive(mk(5, 6, 0), 1, 1, 2'd2, mk(1, 6, 9), 0, 2'd0, 0, "R4 R2 EX imm rt");
    drive(mk(5, 6, 0), 1, 0, 2'd0, 0, 1, 2'd1, mk(0, 0, 5), "R5 WB rr rs");
    drive(mk(5, 6, 0), 1, 0, 2'd0, 0, 1, 2'd1, mk(0, 0, 6), "R5 WB rr rt");
    drive(mk(5, 6, 0), 1, 0, 2'd0, 0, 1, 2'd2, mk(2, 5, 9), "R5 WB imm rs");
    drive(mk(5, 6, 0), 1, 0, 2'd0, 0, 1, 2'd2, mk(2, 6, 9), "R5 WB imm rt");
    drive(mk(5, 6, 0), 1, 0, 2'd0, 0, 1, 2'd3, mk(2, 5, 9), "R6 WB load rs");
    drive(mk(5, 6, 0), 1, 0, 2'd0, 0, 1, 2'd3, mk(2, 6, 9), "R6 WB load rt");
    // Priority and fall-through
    drive(mk(5, 6, 0), 1, 1, 2'd1, mk(0, 0, 5), 1, 2'd3, mk(0, 5, 0), "R8 EX over WB");
    drive(mk(5, 6, 0), 1, 1, 2'd2, mk(0, 6, 0), 1, 2'd1, mk(0, 0, 6), "R8 imm EX over WB");
    drive(mk(5, 6, 0), 1, 1, 2'd3, mk(0, 5, 0), 0, 2'd0, 0, "R7 EX load ignored");
    drive(mk(5, 6, 0), 1, 1, 2'd3, mk(0, 5, 0), 1, 2'd1, mk(0, 0, 5), "R7 EX load falls to WB");
    // Destination field and suppression cases
    drive(mk(5, 6, 0), 1, 1, 2'd1, mk(0, 5, 7), 0, 2'd0, 0, "R2 rr rt not dest");
    drive(mk(5, 6, 0), 1, 1, 2'd2, mk(0, 7, 5), 0, 2'd0, 0, "R2 imm rd not dest");
    drive(mk(0, 0, 0), 1, 1, 2'd1, mk(0, 0, 0), 1, 2'd3, mk(0, 0, 0), "R9 reg zero");
    drive(mk(5, 6, 0), 1, 0, 2'd1, mk(0, 0, 5), 0, 2'd3, mk(0, 6, 0), "R9 invalid producers");
    drive(mk(5, 6, 0), 1, 1, 2'd0, mk(0, 5, 5), 1, 2'd0, mk(0, 6, 6), "R10 store branch");
    drive(mk(5, 6, 0), 0, 1, 2'd1, mk(0, 0, 5), 1, 2'd3, mk(0, 6, 0), "R11 consumer bubble");
    drive(mk(5, 5, 0), 1, 1, 2'd1, mk(0, 0, 5), 0, 2'd0, 0, "R3 both operands");
    // Back-to-back random vectors check one-cycle latency (R12)
    for (int k = 0; k < 400; k++) begin
      drive(mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
            ($urandom_range(0, 7) != 0),
            $urandom_range(0, 1), 2'($urandom_range(0, 3)),
            mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
            $urandom_range(0, 1), 2'($urandom_range(0, 3)),
            mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
            "R12 random");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule